// File: doc/BRIEF.md
# Multi-Lane Receive Deskew

This block lines up as many as eight receive lanes so that words written at the same moment on the far end come out on every lane in the same output cycle. Each lane supplies a 32-bit word of four decoded bytes, with one control flag per byte. A lane counts as marked when its byte 0 carries the selected alignment character with control flag 0 set. The marker word is kept in the stream and is flagged on the output. Each lane has its own small FIFO. In the hunt phase a lane drops its words until its first marker arrives, then stores everything from that marker onward. Once every enabled lane has stored a marker, all FIFOs are read in lockstep.

The state machine has three states. ST_HUNT waits for a marker on every enabled lane. ST_ALIGNED reads all enabled FIFOs together. ST_ERROR lasts one cycle and flushes the FIFOs. The transitions are:
- HUNT→ALIGNED when all enabled lanes have stored a marker.
- HUNT→HUNT with a flush when a lane FIFO overflows.
- ALIGNED→ERROR when the markers at the lane outputs disagree, or when a FIFO overflows.
- ERROR→HUNT unconditionally.
- Any state→HUNT while a passthrough mode is selected.

There are two passthrough modes. Bypass forwards each lane's own strobe and word independently. Raw mode forwards an undecoded 40-bit word per lane and never aligns.

Top module: `lane_deskew`

## Requirements
- R1: After reset, out_valid, out_marker, aligned and deskew_err are all low.
- R2: When cfg_sel_a=1, the marker is byte 0 = 0x7C with control bit 0 set. When cfg_sel_a=0, the marker is byte 0 = 0xBC with control bit 0 set; when cfg_comma_ext=1 the marker is also byte 0 = 0x3C or 0xFC with control bit 0 set. Characters that are not selected never lead to alignment.
- R3: In hunt, a lane drops the words before its marker. The first aligned output word on every lane is that lane's marker, with data and control unchanged and out_marker set. After that, words follow in order with no gaps.
- R4: Let S be the largest marker skew, in cycles, among the enabled lanes, and let edge 0 be the edge that takes in the earliest marker. Then aligned rises at edge S+1, and word n of every enabled lane is presented at edge S+2+n, all lanes in the same cycle.
- R5: Lanes whose bit in cfg_lane_en is 0 are ignored when deciding alignment, and their out_valid stays low.
- R6: Each lane FIFO holds FIFO_DEPTH (default 8) words, so S may be at most FIFO_DEPTH-2. A larger skew overflows a FIFO during hunt; this flushes every lane and restarts the hunt, so aligned never rises.
- R7: A marker on some but not all enabled lanes in one output cycle, or a FIFO overflow, while aligned, causes the following. deskew_err goes high for exactly one cycle, in the same cycle as the mismatching output. aligned drops. The FIFOs are flushed. Hunting then resumes and can realign on later markers.
- R8: With cfg_bypass=1, each enabled lane's in_valid, data, control and marker detection appear on its outputs one cycle later, independently of the other lanes, and aligned stays low.
- R9: With cfg_raw=1, each enabled lane's 40-bit word {in_ext, in_ctl, in_data} appears one cycle later on {out_ext, out_ctl, out_data}. out_marker stays 0 and aligned stays low.
- R10: aligned is high only while in ST_ALIGNED. It is never high together with deskew_err, and in the lockstep modes an output word appears only when aligned is high or deskew_err is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all lanes |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_lane_en | input | NUM_LANES | Lanes taking part |
| cfg_sel_a | input | 1 | 1: 0x7C marker, 0: comma marker |
| cfg_comma_ext | input | 1 | Also accept 0x3C and 0xFC as commas |
| cfg_bypass | input | 1 | Per-lane passthrough without alignment |
| cfg_raw | input | 1 | Raw 40-bit passthrough, alignment disabled |
| in_valid | input | NUM_LANES | Per-lane word strobe |
| in_data | input | NUM_LANES*32 | Per-lane data bytes |
| in_ctl | input | NUM_LANES*4 | Per-lane control flag per byte |
| in_ext | input | NUM_LANES*4 | Upper raw bits, used only in raw mode |
| out_valid | output | NUM_LANES | Per-lane output strobe |
| out_data | output | NUM_LANES*32 | Per-lane output data |
| out_ctl | output | NUM_LANES*4 | Per-lane output control flags |
| out_ext | output | NUM_LANES*4 | Upper raw bits in raw mode, else 0 |
| out_marker | output | NUM_LANES | Output word is an alignment marker |
| aligned | output | 1 | High while lanes are read in lockstep |
| deskew_err | output | 1 | One-cycle pulse on entry to the error state |

## Verification
The checker watches several properties on every cycle:
- the single-cycle width of deskew_err and its exclusion with aligned;
- that a lockstep output either covers exactly the enabled lanes or covers none;
- that marker flags agree across lanes unless an error is being raised;
- that the bypass and raw paths echo their inputs one cycle later without aligning.

Other behaviour can only be shown by the bench scenarios. These include the exact latency S+2 across a sweep of skews from 0 to 6, and the refusal to align at skew 7. They also include the discarding of pre-marker words and the selection between marker codes. Finally, the bench checks the position of the error pulse after a marker is dropped on one lane, and the realignment that follows.

// File: rtl/lane_deskew_pkg.sv
package lane_deskew_pkg;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_ALIGNED = 2'd1,
        ST_ERROR   = 2'd2
    } dsk_state_e;

    localparam logic [7:0] K28_1 = 8'h3C;
    localparam logic [7:0] K28_3 = 8'h7C;
    localparam logic [7:0] K28_5 = 8'hBC;
    localparam logic [7:0] K28_7 = 8'hFC;

endpackage

// File: rtl/lane_marker_det.sv
module lane_marker_det
    import lane_deskew_pkg::*;
(
    input  logic [7:0] byte0,
    input  logic       ctl0,
    input  logic       sel_a,
    input  logic       comma_ext,
    output logic       hit
);

    logic is_a;
    logic is_comma;

    always_comb begin
        is_a     = (byte0 == K28_3);
        is_comma = (byte0 == K28_5) ||
                   (comma_ext && ((byte0 == K28_1) || (byte0 == K28_7)));
        hit      = ctl0 && (sel_a ? is_a : is_comma);
    end

endmodule

// File: rtl/lane_fifo.sv
module lane_fifo #(
    parameter int W     = 37,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;
    logic [CW-1:0] cnt;
    logic          rd_ok;
    logic          wr_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign rd_ok   = rd_en && !empty;
    assign wr_ok   = wr_en && (!full || rd_ok);
    assign rd_data = mem[rp];

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr_ok) wp <= bump(wp);
            if (rd_ok) rp <= bump(rp);
            cnt <= cnt + CW'(wr_ok) - CW'(rd_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok && !flush) mem[wp] <= wr_data;
    end

endmodule

// File: rtl/lane_deskew_fsm.sv
module lane_deskew_fsm
    import lane_deskew_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold,
    input  logic       all_seen,
    input  logic       overflow,
    input  logic       mismatch,
    output dsk_state_e state,
    output logic       flush,
    output logic       aligned,
    output logic       deskew_err
);

    dsk_state_e state_n;

    always_comb begin
        state_n = state;
        unique case (state)
            ST_HUNT: begin
                if (hold || overflow) state_n = ST_HUNT;
                else if (all_seen)    state_n = ST_ALIGNED;
            end
            ST_ALIGNED: begin
                if (hold)                     state_n = ST_HUNT;
                else if (mismatch || overflow) state_n = ST_ERROR;
            end
            ST_ERROR: state_n = ST_HUNT;
            default:  state_n = ST_HUNT;
        endcase
    end

    assign flush = hold || (state == ST_ERROR) || ((state == ST_HUNT) && overflow);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aligned    <= 1'b0;
            deskew_err <= 1'b0;
        end else begin
            aligned    <= (state_n == ST_ALIGNED);
            deskew_err <= (state_n == ST_ERROR) && (state != ST_ERROR);
        end
    end

endmodule

// File: rtl/lane_deskew.sv
module lane_deskew
    import lane_deskew_pkg::*;
#(
    parameter int NUM_LANES  = 8,
    parameter int DATA_W     = 32,
    parameter int RAW_W      = 40,
    parameter int FIFO_DEPTH = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_LANES-1:0]          cfg_lane_en,
    input  logic                          cfg_sel_a,
    input  logic                          cfg_comma_ext,
    input  logic                          cfg_bypass,
    input  logic                          cfg_raw,
    input  logic [NUM_LANES-1:0]          in_valid,
    input  logic [NUM_LANES*DATA_W-1:0]   in_data,
    input  logic [NUM_LANES*(DATA_W/8)-1:0] in_ctl,
    input  logic [NUM_LANES*(RAW_W-DATA_W-DATA_W/8)-1:0] in_ext,
    output logic [NUM_LANES-1:0]          out_valid,
    output logic [NUM_LANES*DATA_W-1:0]   out_data,
    output logic [NUM_LANES*(DATA_W/8)-1:0] out_ctl,
    output logic [NUM_LANES*(RAW_W-DATA_W-DATA_W/8)-1:0] out_ext,
    output logic [NUM_LANES-1:0]          out_marker,
    output logic                          aligned,
    output logic                          deskew_err
);

    localparam int CTL_W = DATA_W / 8;
    localparam int EXT_W = RAW_W - DATA_W - CTL_W;
    localparam int FW    = DATA_W + CTL_W + 1;

    dsk_state_e           state;
    logic                 flush;
    logic                 hold;
    logic                 any_en;
    logic                 all_seen;
    logic                 all_ready;
    logic                 rd_fire;
    logic                 overflow;
    logic                 mismatch;
    logic [NUM_LANES-1:0] hit;
    logic [NUM_LANES-1:0] seen_q;
    logic [NUM_LANES-1:0] wr;
    logic [NUM_LANES-1:0] full;
    logic [NUM_LANES-1:0] empty;
    logic [NUM_LANES-1:0] head_mk;
    logic [FW-1:0]        head [NUM_LANES];

    assign hold      = cfg_bypass || cfg_raw;
    assign any_en    = |cfg_lane_en;
    assign all_seen  = any_en && (&(seen_q | ~cfg_lane_en));
    assign all_ready = any_en && (&(~empty | ~cfg_lane_en));
    assign rd_fire   = (state == ST_ALIGNED) && !hold && all_ready;
    assign overflow  = |(wr & full & ~{NUM_LANES{rd_fire}});
    assign mismatch  = rd_fire && (|head_mk) && (head_mk != cfg_lane_en);

    lane_deskew_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (hold),
        .all_seen   (all_seen),
        .overflow   (overflow),
        .mismatch   (mismatch),
        .state      (state),
        .flush      (flush),
        .aligned    (aligned),
        .deskew_err (deskew_err)
    );

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        logic [DATA_W-1:0] d_in;
        logic [CTL_W-1:0]  c_in;

        assign d_in = in_data[i*DATA_W +: DATA_W];
        assign c_in = in_ctl[i*CTL_W +: CTL_W];

        lane_marker_det u_det (
            .byte0     (d_in[7:0]),
            .ctl0      (c_in[0]),
            .sel_a     (cfg_sel_a),
            .comma_ext (cfg_comma_ext),
            .hit       (hit[i])
        );

        assign wr[i] = !hold && cfg_lane_en[i] && in_valid[i] &&
                       ((state == ST_ALIGNED) ||
                        ((state == ST_HUNT) && (seen_q[i] || hit[i])));

        lane_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .flush   (flush),
            .wr_en   (wr[i]),
            .wr_data ({hit[i], c_in, d_in}),
            .rd_en   (rd_fire),
            .rd_data (head[i]),
            .empty   (empty[i]),
            .full    (full[i])
        );

        assign head_mk[i] = head[i][FW-1] && cfg_lane_en[i];

        always_ff @(posedge clk) begin
            if (!rst_n || flush)                          seen_q[i] <= 1'b0;
            else if ((state == ST_HUNT) && wr[i] && hit[i]) seen_q[i] <= 1'b1;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_valid[i]                    <= 1'b0;
                out_marker[i]                   <= 1'b0;
                out_data[i*DATA_W +: DATA_W]    <= '0;
                out_ctl[i*CTL_W +: CTL_W]       <= '0;
                out_ext[i*EXT_W +: EXT_W]       <= '0;
            end else if (hold) begin
                out_valid[i]                    <= in_valid[i] && cfg_lane_en[i];
                out_marker[i]                   <= !cfg_raw && in_valid[i] && cfg_lane_en[i] && hit[i];
                out_data[i*DATA_W +: DATA_W]    <= d_in;
                out_ctl[i*CTL_W +: CTL_W]       <= c_in;
                out_ext[i*EXT_W +: EXT_W]       <= cfg_raw ? in_ext[i*EXT_W +: EXT_W] : '0;
            end else begin
                out_valid[i]                    <= rd_fire && cfg_lane_en[i];
                out_marker[i]                   <= rd_fire && head_mk[i];
                out_data[i*DATA_W +: DATA_W]    <= head[i][DATA_W-1:0];
                out_ctl[i*CTL_W +: CTL_W]       <= head[i][DATA_W +: CTL_W];
                out_ext[i*EXT_W +: EXT_W]       <= '0;
            end
        end
    end

endmodule

// File: rtl/lane_deskew_chk.sv
module lane_deskew_chk #(
    parameter int NUM_LANES = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LANES-1:0] cfg_lane_en,
    input logic                 cfg_bypass,
    input logic                 cfg_raw,
    input logic [NUM_LANES-1:0] in_valid,
    input logic [NUM_LANES-1:0] out_valid,
    input logic [NUM_LANES-1:0] out_marker,
    input logic                 aligned,
    input logic                 deskew_err
);

    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        deskew_err |=> !deskew_err); // R7

    AST_ERR_NOT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        deskew_err |-> !aligned); // R10

    AST_RAW_NO_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_raw |=> (!aligned && out_marker == '0)); // R9

    AST_BYPASS_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bypass && !cfg_raw) |=> (out_valid == $past(in_valid & cfg_lane_en) && !aligned)); // R8

    AST_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_bypass && !cfg_raw) |=> (out_valid == '0 || out_valid == $past(cfg_lane_en))); // R4

    AST_MARK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_bypass && !cfg_raw) |=> (deskew_err || (out_marker & out_valid) == '0 ||
                                       (out_marker & out_valid) == out_valid)); // R7

    AST_OUT_ONLY_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_bypass && !cfg_raw) |=> (out_valid == '0 || aligned || deskew_err)); // R10

endmodule

bind lane_deskew lane_deskew_chk #(.NUM_LANES(NUM_LANES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_lane_en (cfg_lane_en),
    .cfg_bypass  (cfg_bypass),
    .cfg_raw     (cfg_raw),
    .in_valid    (in_valid),
    .out_valid   (out_valid),
    .out_marker  (out_marker),
    .aligned     (aligned),
    .deskew_err  (deskew_err)
);

// File: tb/lane_deskew_bench.sv
`timescale 1ns/1ps
module lane_deskew_bench;

    localparam int NL = 8;
    localparam int DW = 32;
    localparam int CW = 4;
    localparam int EW = 4;
    localparam int P  = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NL-1:0]   cfg_lane_en = '1;
    logic            cfg_sel_a = 1'b0;
    logic            cfg_comma_ext = 1'b0;
    logic            cfg_bypass = 1'b0;
    logic            cfg_raw = 1'b0;
    logic [NL-1:0]   in_valid = '0;
    logic [NL*DW-1:0] in_data = '0;
    logic [NL*CW-1:0] in_ctl = '0;
    logic [NL*EW-1:0] in_ext = '0;
    logic [NL-1:0]   out_valid;
    logic [NL*DW-1:0] out_data;
    logic [NL*CW-1:0] out_ctl;
    logic [NL*EW-1:0] out_ext;
    logic [NL-1:0]   out_marker;
    logic            aligned;
    logic            deskew_err;

    always #2.5 clk = ~clk;

    lane_deskew u_lane_deskew (
        .clk(clk), .rst_n(rst_n), .cfg_lane_en(cfg_lane_en), .cfg_sel_a(cfg_sel_a),
        .cfg_comma_ext(cfg_comma_ext), .cfg_bypass(cfg_bypass), .cfg_raw(cfg_raw),
        .in_valid(in_valid), .in_data(in_data), .in_ctl(in_ctl), .in_ext(in_ext),
        .out_valid(out_valid), .out_data(out_data), .out_ctl(out_ctl), .out_ext(out_ext),
        .out_marker(out_marker), .aligned(aligned), .deskew_err(deskew_err)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int skew [NL];
    logic [7:0] mk_code = 8'hBC;
    int  drop_n = -1;
    bit  vgap = 1'b0;

    int  first_edge, first_n, first_al, n_outs, bad, n_err, err_edge, prev_n;
    bit  err_al, al_end, ever_al, had_prev;
    logic [DW-1:0] pd [NL];
    logic [CW-1:0] pk [NL];
    logic [EW-1:0] pe [NL];
    logic [NL-1:0] pv;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void make_word(input int lane, input int n,
                                      output logic [DW-1:0] d, output logic [CW-1:0] k);
        if (n < 0) begin
            d = {8'(lane), 16'hFFFF, 8'h11};
            k = 4'b0000;
        end else if ((n % P) == 0 && !(lane == 0 && n == drop_n)) begin
            d = {8'(lane), 16'(n), mk_code};
            k = 4'b0001;
        end else begin
            d = {8'(lane), 16'(n), 8'h22};
            k = ((n % 5) == 1) ? 4'b0100 : 4'b0000;
        end
    endfunction

    function automatic bit exp_mk(input logic [DW-1:0] d, input logic [CW-1:0] k);
        if (!k[0]) return 1'b0;
        if (cfg_sel_a) return d[7:0] == 8'h7C;
        return (d[7:0] == 8'hBC) || (cfg_comma_ext && (d[7:0] == 8'h3C || d[7:0] == 8'hFC));
    endfunction

    task automatic drive(input int c);
        for (int i = 0; i < NL; i++) begin
            logic [DW-1:0] d;
            logic [CW-1:0] k;
            make_word(i, c - skew[i], d, k);
            in_data[i*DW +: DW] = d;
            in_ctl[i*CW +: CW]  = k;
            in_ext[i*EW +: EW]  = 4'(c + i);
            in_valid[i]         = vgap ? (((c + i) % 3) != 0) : 1'b1;
            pd[i] = d; pk[i] = k; pe[i] = 4'(c + i); pv[i] = in_valid[i];
        end
    endtask

    task automatic obs(input int e);
        if (aligned) begin
            ever_al = 1'b1;
            if (first_al < 0) first_al = e;
        end
        if (deskew_err) begin
            n_err++;
            err_edge = e;
            err_al   = aligned;
        end
        if (cfg_bypass || cfg_raw) begin
            if (aligned) bad++;
            for (int i = 0; i < NL; i++) begin
                bit ev;
                ev = pv[i] && cfg_lane_en[i];
                if (out_valid[i] != ev) bad++;
                if (ev) begin
                    if (out_data[i*DW +: DW] != pd[i]) bad++;
                    if (out_ctl[i*CW +: CW] != pk[i]) bad++;
                    if (out_ext[i*EW +: EW] != (cfg_raw ? pe[i] : 4'h0)) bad++;
                    if (out_marker[i] != (cfg_raw ? 1'b0 : exp_mk(pd[i], pk[i]))) bad++;
                end
            end
        end else if (out_valid != '0) begin
            int lo;
            int n;
            lo = 0;
            for (int i = NL - 1; i >= 0; i--) if (cfg_lane_en[i]) lo = i;
            n = int'(out_data[lo*DW + 8 +: 16]);
            n_outs++;
            if (first_edge < 0) begin
                first_edge = e;
                first_n    = n;
            end
            if (had_prev && n != prev_n + 1) bad++;
            if (out_valid != cfg_lane_en) bad++;
            for (int i = 0; i < NL; i++) begin
                if (cfg_lane_en[i]) begin
                    logic [DW-1:0] d;
                    logic [CW-1:0] k;
                    make_word(i, n, d, k);
                    if (out_data[i*DW +: DW] != d) bad++;
                    if (out_ctl[i*CW +: CW] != k) bad++;
                    if (out_marker[i] != k[0]) bad++;
                    if (out_ext[i*EW +: EW] != 4'h0) bad++;
                end
            end
            had_prev = 1'b1;
            prev_n   = n;
        end else begin
            had_prev = 1'b0;
        end
    endtask

    task automatic do_reset();
        rst_n    = 1'b0;
        in_valid = '0;
        in_data  = '0;
        in_ctl   = '0;
        in_ext   = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run(input int ncyc);
        first_edge = -1; first_n = -1; first_al = -1; n_outs = 0; bad = 0;
        n_err = 0; err_edge = -1; err_al = 1'b0; ever_al = 1'b0; had_prev = 1'b0; prev_n = 0;
        do_reset();
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            if (c > 0) obs(c - 1);
            drive(c);
        end
        @(negedge clk);
        obs(ncyc - 1);
        al_end = aligned;
    endtask

    task automatic set_skew_mod(input int m);
        for (int i = 0; i < NL; i++) skew[i] = i % m;
    endtask

    initial begin
        #(5.0 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        set_skew_mod(1);
        do_reset();
        #1;
        // R1: quiet outputs after reset
        chk(out_valid == '0 && out_marker == '0, "R1", "out_valid/out_marker after reset", int'(out_valid), 0);
        chk(!aligned && !deskew_err, "R1", "aligned/deskew_err after reset", int'({aligned, deskew_err}), 0);

        // R4/R3: skew sweep 0..FIFO_DEPTH-2
        for (int s = 0; s <= 6; s++) begin
            for (int i = 0; i < NL; i++) skew[i] = (i == NL - 1) ? s : (i * 3) % (s + 1);
            run(60);
            chk(first_al == s + 1, "R4", $sformatf("aligned edge skew %0d", s), first_al, s + 1);
            chk(first_edge == s + 2, "R4", $sformatf("first output edge skew %0d", s), first_edge, s + 2);
            chk(n_outs == 58 - s, "R4", $sformatf("output count skew %0d", s), n_outs, 58 - s);
            chk(first_n == 0, "R3", $sformatf("first word is marker skew %0d", s), first_n, 0);
            chk(bad == 0, "R3", $sformatf("lockstep words skew %0d", s), bad, 0);
            chk(n_err == 0, "R7", $sformatf("no error skew %0d", s), n_err, 0);
        end

        // R6: skew 7 overflows in hunt and never aligns
        set_skew_mod(4);
        skew[NL-1] = 7;
        run(80);
        chk(!ever_al, "R6", "aligned with skew 7", int'(ever_al), 0);
        chk(n_outs == 0, "R6", "outputs with skew 7", n_outs, 0);

        // R5: disabling the far lane lets the rest align
        cfg_lane_en = 8'h7F;
        run(60);
        chk(first_edge == 5, "R5", "first output edge with lane 7 off", first_edge, 5);
        chk(bad == 0, "R5", "lane 7 silent, others lockstep", bad, 0);
        chk(al_end, "R5", "aligned at end", int'(al_end), 1);
        cfg_lane_en = '1;

        // R2: marker selection
        set_skew_mod(2);
        cfg_sel_a = 1'b1; mk_code = 8'hBC;
        run(40);
        chk(!ever_al, "R2", "/A/ select ignores 0xBC", int'(ever_al), 0);
        mk_code = 8'h7C;
        run(40);
        chk(first_edge == 3 && bad == 0, "R2", "/A/ select aligns on 0x7C", first_edge, 3);
        cfg_sel_a = 1'b0;
        run(40);
        chk(!ever_al, "R2", "comma select ignores 0x7C", int'(ever_al), 0);
        mk_code = 8'h3C;
        run(40);
        chk(!ever_al, "R2", "0x3C without extension", int'(ever_al), 0);
        cfg_comma_ext = 1'b1;
        run(40);
        chk(first_edge == 3 && bad == 0, "R2", "0x3C with extension", first_edge, 3);
        mk_code = 8'hFC;
        run(40);
        chk(first_edge == 3 && bad == 0, "R2", "0xFC with extension", first_edge, 3);
        cfg_comma_ext = 1'b0; mk_code = 8'hBC;

        // R7: lane 0 drops its marker at word 16
        set_skew_mod(4);
        drop_n = 16;
        run(90);
        chk(n_err == 1, "R7", "error pulse count", n_err, 1);
        chk(err_edge == 21, "R7", "error pulse edge", err_edge, 21);
        chk(!err_al, "R10", "aligned low during error", int'(err_al), 0);
        chk(bad == 0, "R7", "words before and after error", bad, 0);
        chk(al_end, "R7", "realigned on later markers", int'(al_end), 1);
        drop_n = -1;

        // R8: bypass, gapped strobes, one lane disabled
        cfg_bypass = 1'b1; vgap = 1'b1; cfg_lane_en = 8'hDF;
        run(40);
        chk(bad == 0, "R8", "bypass echo mismatches", bad, 0);
        chk(!ever_al, "R8", "aligned in bypass", int'(ever_al), 0);
        cfg_bypass = 1'b0; vgap = 1'b0; cfg_lane_en = '1;

        // R9: raw 40-bit passthrough
        cfg_raw = 1'b1;
        run(40);
        chk(bad == 0, "R9", "raw echo mismatches", bad, 0);
        chk(!ever_al, "R9", "aligned in raw mode", int'(ever_al), 0);
        cfg_raw = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule